// File: doc/BRIEF.md
# Dual-Window Video Memory Bank Mapper

This block turns a CPU real-mode address that lands in the legacy graphics memory window into an address in video memory. Two 8-bit bank offset registers, A and B, each select a start point in video memory in 4 KB steps. When bank B is disabled, bank A maps the whole window. When bank B is enabled, the window is split between the two banks. How it is split depends on whether the window is configured as 64 KB or 128 KB.

The mapping is purely combinational. It sits between the CPU bus decoder and the video memory controller. A CPU address outside the configured window clears the hit flag and gives a zero address. Every translated address wraps modulo the installed memory size that the memory-size code reports.

Top module: `vmem_bank_mapper`

## Requirements
- R1: With `bank_b_en`=0 and `win_128k`=0 the window is 0xA0000–0xAFFFF, and `mem_addr` = `bank_a`·4096 + (`cpu_addr` − 0xA0000).
- R2: With `bank_b_en`=0 and `win_128k`=1 the window is 0xA0000–0xBFFFF, and bank A maps all of it: `mem_addr` = `bank_a`·4096 + (`cpu_addr` − 0xA0000).
- R3: With `bank_b_en`=1 and `win_128k`=0, addresses 0xA0000–0xA7FFF map through bank B: `mem_addr` = `bank_b`·4096 + (`cpu_addr` − 0xA0000).
- R4: With `bank_b_en`=1 and `win_128k`=0, addresses 0xA8000–0xAFFFF map through bank A: `mem_addr` = `bank_a`·4096 + (`cpu_addr` − 0xA8000).
- R5: With `bank_b_en`=1 and `win_128k`=1, addresses 0xA0000–0xAFFFF map through bank B with offset from 0xA0000, and addresses 0xB0000–0xBFFFF map through bank A with offset from 0xB0000.
- R6: An address outside the configured window drives `hit`=0 and `mem_addr`=0. An address inside it drives `hit`=1.
- R7: `mem_addr` wraps modulo the installed size. `mem_size` code 3 means 1 MB, code 2 means 512 KB, and codes 1 and 0 both mean 256 KB.
- R8: All 8 bits of a bank register take part in the mapping, so bank 0xFF reaches 0xFF000 in a 1 MB memory.
- R9: The mapping has no storage. A change to a bank register or to a mode input shows at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 20 | CPU real-mode byte address |
| bank_a | input | 8 | Bank A offset, in 4 KB units |
| bank_b | input | 8 | Bank B offset, in 4 KB units |
| bank_b_en | input | 1 | Enables the split window that uses bank B |
| win_128k | input | 1 | 1: 128 KB window, 0: 64 KB window |
| mem_size | input | 2 | Installed memory size code (see R7) |
| mem_addr | output | 20 | Translated video memory address |
| hit | output | 1 | High when `cpu_addr` is inside the window |

## Verification
The bench probes the edges of each split: 0xA7FFF against 0xA8000 in the 64 KB dual layout, and 0xAFFFF against 0xB0000 in the 128 KB dual layout. A mapper that put the split in the wrong place, or that took the offset from the wrong base, would give a translated address off by 32 KB or 64 KB there. The bench checks 0x9FFFF, 0xC0000, and 0xB0000 in a 64 KB window, where a loose window test would report a false hit. It also drives bank values whose sums cross the 256 KB, 512 KB and 1 MB limits; a missing or wrong wrap mask shows up as a high address bit that should have been cleared. Last, it changes the bank and the mode with no clock edge in between, which catches any stage that was registered by mistake.

// File: rtl/vmem_bank_mapper.sv
module vmem_bank_mapper #(
  parameter int CPU_AW  = 20,
  parameter int BANK_W  = 8,
  parameter int GRAN_SH = 12,
  parameter int MEM_AW  = 20,
  parameter logic [CPU_AW-1:0] WIN_BASE = 20'hA0000
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BANK_W-1:0] bank_a,
  input  logic [BANK_W-1:0] bank_b,
  input  logic              bank_b_en,
  input  logic              win_128k,
  input  logic [1:0]        mem_size,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              hit
);
  localparam int OFF_W = 17;
  localparam logic [CPU_AW-1:0] SEG  = CPU_AW'(1 << 16);
  localparam logic [CPU_AW-1:0] HALF = CPU_AW'(1 << 15);
  localparam logic [CPU_AW:0]   END64  = {1'b0, WIN_BASE} + {1'b0, SEG};
  localparam logic [CPU_AW:0]   END128 = {1'b0, WIN_BASE} + {1'b0, SEG} + {1'b0, SEG};

  logic [CPU_AW-1:0] rel;
  logic              in_win, use_b;
  logic [OFF_W-1:0]  offset;
  logic [BANK_W-1:0] bank;
  logic [MEM_AW:0]   sum;
  logic [1:0]        shamt;
  logic [MEM_AW-1:0] mask;

  assign rel    = cpu_addr - WIN_BASE;
  assign in_win = (cpu_addr >= WIN_BASE) &&
                  ({1'b0, cpu_addr} < (win_128k ? END128 : END64));
  assign use_b  = bank_b_en && (win_128k ? (rel < SEG) : (rel < HALF));
  assign bank   = use_b ? bank_b : bank_a;

  always_comb begin
    if (!bank_b_en || use_b) offset = rel[OFF_W-1:0];
    else if (win_128k)       offset = OFF_W'(rel - SEG);
    else                     offset = OFF_W'(rel - HALF);
  end

  assign sum   = (MEM_AW+1)'({bank, {GRAN_SH{1'b0}}}) + (MEM_AW+1)'(offset);
  assign shamt = (mem_size == 2'd0) ? 2'd2 : 2'd3 - mem_size;
  assign mask  = {MEM_AW{1'b1}} >> shamt;

  assign hit      = in_win;
  assign mem_addr = in_win ? (sum[MEM_AW-1:0] & mask) : '0;

  always_comb begin
    if (cpu_addr < WIN_BASE)
      assert_below_window_R6: assert (!hit && mem_addr == '0)
        else $error("R6 address below window produced hit or address");
    if (!hit)
      assert_miss_zero_R6: assert (mem_addr == '0)
        else $error("R6 miss with nonzero address");
    if (mem_size == 2'd1)
      assert_wrap_256k_R7: assert (mem_addr < MEM_AW'(1 << (MEM_AW - 2)))
        else $error("R7 address beyond 256 KB");
    if (mem_size == 2'd2)
      assert_wrap_512k_R7: assert (mem_addr < MEM_AW'(1 << (MEM_AW - 1)))
        else $error("R7 address beyond 512 KB");
    if (hit)
      assert_page_offset_R1: assert (mem_addr[GRAN_SH-1:0] == cpu_addr[GRAN_SH-1:0])
        else $error("R1 low offset bits not preserved");
  end
endmodule

// File: tb/test_vmem_bank_mapper.sv
module test_vmem_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic [7:0]  bank_a = '0, bank_b = '0;
  logic        bank_b_en = 1'b0, win_128k = 1'b0;
  logic [1:0]  mem_size = 2'd3;
  logic [19:0] mem_addr;
  logic        hit;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vmem_bank_mapper i_vmem_bank_mapper (
    .cpu_addr(cpu_addr), .bank_a(bank_a), .bank_b(bank_b),
    .bank_b_en(bank_b_en), .win_128k(win_128k), .mem_size(mem_size),
    .mem_addr(mem_addr), .hit(hit)
  );

  typedef struct packed {
    logic [19:0] cpu;
    logic [7:0]  ba, bb;
    logic        en, w128;
    logic [1:0]  msz;
    logic        ehit;
    logic [19:0] eaddr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{20'hA0123, 8'h10, 8'h00, 1'b0, 1'b0, 2'd3, 1'b1, 20'h10123, 8'd1}, // R1
    '{20'hAFFFF, 8'h01, 8'h00, 1'b0, 1'b0, 2'd3, 1'b1, 20'h10FFF, 8'd1}, // R1
    '{20'hBFFFF, 8'h00, 8'h00, 1'b0, 1'b1, 2'd3, 1'b1, 20'h1FFFF, 8'd2}, // R2
    '{20'hB0000, 8'h02, 8'h00, 1'b0, 1'b1, 2'd3, 1'b1, 20'h12000, 8'd2}, // R2
    '{20'hA7FFF, 8'h20, 8'h05, 1'b1, 1'b0, 2'd3, 1'b1, 20'h0CFFF, 8'd3}, // R3
    '{20'hA0000, 8'h20, 8'h05, 1'b1, 1'b0, 2'd3, 1'b1, 20'h05000, 8'd3}, // R3
    '{20'hA8000, 8'h20, 8'h05, 1'b1, 1'b0, 2'd3, 1'b1, 20'h20000, 8'd4}, // R4
    '{20'hAFFFF, 8'h20, 8'h05, 1'b1, 1'b0, 2'd3, 1'b1, 20'h27FFF, 8'd4}, // R4
    '{20'hAFFFF, 8'h20, 8'h05, 1'b1, 1'b1, 2'd3, 1'b1, 20'h14FFF, 8'd5}, // R5
    '{20'hB0001, 8'h20, 8'h05, 1'b1, 1'b1, 2'd3, 1'b1, 20'h20001, 8'd5}, // R5
    '{20'hB0000, 8'h20, 8'h05, 1'b1, 1'b0, 2'd3, 1'b0, 20'h00000, 8'd6}, // R6
    '{20'h9FFFF, 8'h20, 8'h05, 1'b0, 1'b1, 2'd3, 1'b0, 20'h00000, 8'd6}, // R6
    '{20'hC0000, 8'h20, 8'h05, 1'b1, 1'b1, 2'd3, 1'b0, 20'h00000, 8'd6}, // R6
    '{20'hA0010, 8'h40, 8'h00, 1'b0, 1'b0, 2'd1, 1'b1, 20'h00010, 8'd7}, // R7
    '{20'hA0010, 8'h85, 8'h00, 1'b0, 1'b0, 2'd2, 1'b1, 20'h05010, 8'd7}, // R7
    '{20'hA0010, 8'h40, 8'h00, 1'b0, 1'b0, 2'd0, 1'b1, 20'h00010, 8'd7}, // R7
    '{20'hAFFFF, 8'hFF, 8'h00, 1'b0, 1'b0, 2'd3, 1'b1, 20'h0EFFF, 8'd8}, // R8
    '{20'hA0000, 8'hFF, 8'h00, 1'b0, 1'b0, 2'd3, 1'b1, 20'hFF000, 8'd8}  // R8
  };

  task automatic check(input logic ehit, input logic [19:0] eaddr, input string req);
    checks++;
    if (hit !== ehit || mem_addr !== eaddr) begin
      fails++;
      $display("FAIL %s: hit=%0b addr=%05h expected hit=%0b addr=%05h",
               req, hit, mem_addr, ehit, eaddr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 20'h0, "R6 reset state");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cpu_addr = VEC[i].cpu; bank_a = VEC[i].ba; bank_b = VEC[i].bb;
      bank_b_en = VEC[i].en; win_128k = VEC[i].w128; mem_size = VEC[i].msz;
      @(negedge clk);
      check(VEC[i].ehit, VEC[i].eaddr, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end
    // R9: a bank change takes effect with no clock edge in between
    @(negedge clk);
    cpu_addr = 20'hA0004; bank_a = 8'h03; bank_b_en = 1'b0; win_128k = 1'b0; mem_size = 2'd3;
    #1 check(1'b1, 20'h03004, "R9 first bank");
    bank_a = 8'h07;
    #1 check(1'b1, 20'h07004, "R9 bank change");
    bank_b = 8'h09; bank_b_en = 1'b1;
    #1 check(1'b1, 20'h09004, "R9 split enable");
    win_128k = 1'b1; cpu_addr = 20'hB0004;
    #1 check(1'b1, 20'h07004, "R9 window resize");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule